// File: doc/BRIEF.md
# Rate-Switch FIFO Pointer Reset Controller

This block coordinates a change of line rate across a group of bonded serial lanes that share one parallel interface clock. The lane group runs either at the slow rate (125 MHz parallel clock, 2.5 Gbps line) or at the fast rate (250 MHz parallel clock, 5 Gbps line). During the clock change, the write and read sides of each phase-compensation FIFO can briefly see clocks that disagree, so the pointers could collide.

A change of level on the rate-select input, in either direction, starts a switch sequence. The transmit and receive phase-compensation FIFO pointers of every lane are then disabled and held in reset. The clock divider signals that the switch is complete with a one-cycle done pulse. The block then lets the pointers go and, one cycle later, pulses a per-lane completion flag on all lanes together. The rate output takes its new value in that same cycle.

Top module: `rsw_ptr_reset_ctrl`

## Requirements
- R1: After reset, every pointer reset output is 0, every pointer enable is 1, every lane done flag is 0 and `rate_o` is 0 (slow rate).
- R2: A change of `rate_sel_i` in either direction (0 = slow/125 MHz, 1 = fast/250 MHz) puts all transmit and receive pointer resets at 1 and all enables at 0. This takes effect from the second rising edge after the edge that first samples the new level.
- R3: All lanes always show the same pointer reset value on both the transmit and receive sides, and each enable is the inverse of its reset.
- R4: The hold lasts for as long as `clk_sw_done_i` stays low, with no limit. It ends at the rising edge that samples `clk_sw_done_i` high, and the pointer resets are 0 after that edge.
- R5: One cycle after the release, `lane_done_o` is 1 on all lanes at once for exactly one cycle.
- R6: `rate_o` changes only in the cycle in which `lane_done_o` is high. It then takes the level that `rate_sel_i` had at its most recent change.
- R7: A `clk_sw_done_i` pulse while no switch is in progress has no effect on any output.
- R8: A new change of `rate_sel_i` during the hold, the release cycle or the done cycle restarts the hold. If it coincides with `clk_sw_done_i`, the change wins and the pointers stay in reset. A change seen in the release cycle suppresses that done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 1 | Requested rate level, 0 slow, 1 fast |
| clk_sw_done_i | input | 1 | One-cycle pulse from the clock divider: switch complete |
| tx_ptr_rst_o | output | LANES | Transmit FIFO pointer reset per lane |
| rx_ptr_rst_o | output | LANES | Receive FIFO pointer reset per lane |
| tx_ptr_en_o | output | LANES | Transmit FIFO pointer enable per lane |
| rx_ptr_en_o | output | LANES | Receive FIFO pointer enable per lane |
| lane_done_o | output | LANES | Per-lane switch completion pulse |
| rate_o | output | 1 | Current rate, 0 slow, 1 fast |

## Verification
A sequencer stuck in its hold state shows at the ports as pointer resets that never drop after a done pulse, which is visible one edge later. A sequencer that skips the hold shows no reset two edges after a rate change. A wrong stored target shows as a wrong `rate_o` in the done cycle. A lost restart shows as a done pulse, or a released pointer, within two cycles of a second rate change. Sweeps over hold lengths and both directions expose each of these within a few cycles of the event that causes it.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_HOLD    = 2'd1,
        SEQ_RELEASE = 2'd2,
        SEQ_DONE    = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       target;
        logic       rate;
    } seq_regs_t;

    typedef struct packed {
        logic level;
        logic prev;
    } edge_regs_t;

endpackage

// File: rtl/rsw_edge_detect.sv
module rsw_edge_detect
    import rsw_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic lvl_o,
    output logic evt_o
);

    edge_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.level = lvl_i;
        r_d.prev  = r_q.level;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // a toggle between the last two samples is one switch event
    assign evt_o = r_q.level ^ r_q.prev;
    assign lvl_o = r_q.level;

endmodule

// File: rtl/rsw_seq_fsm.sv
module rsw_seq_fsm
    import rsw_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic lvl_i,
    input  logic sw_done_i,
    output logic hold_o,
    output logic done_o,
    output logic rate_o
);

    seq_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            SEQ_IDLE: begin
                if (evt_i) begin
                    s_d.st     = SEQ_HOLD;
                    s_d.target = lvl_i;
                end
            end
            SEQ_HOLD: begin
                if (evt_i) begin
                    s_d.target = lvl_i;
                end else if (sw_done_i) begin
                    s_d.st = SEQ_RELEASE;
                end
            end
            SEQ_RELEASE: begin
                if (evt_i) begin
                    s_d.st     = SEQ_HOLD;
                    s_d.target = lvl_i;
                end else begin
                    s_d.st   = SEQ_DONE;
                    s_d.rate = s_q.target;
                end
            end
            SEQ_DONE: begin
                if (evt_i) begin
                    s_d.st     = SEQ_HOLD;
                    s_d.target = lvl_i;
                end else begin
                    s_d.st = SEQ_IDLE;
                end
            end
            default: s_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '{st: SEQ_IDLE, target: 1'b0, rate: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign hold_o = (s_q.st == SEQ_HOLD);
    assign done_o = (s_q.st == SEQ_DONE);
    assign rate_o = s_q.rate;

endmodule

// File: rtl/rsw_lane_gate.sv
module rsw_lane_gate (
    input  logic hold_i,
    input  logic done_i,
    output logic tx_rst_o,
    output logic rx_rst_o,
    output logic tx_en_o,
    output logic rx_en_o,
    output logic done_o
);

    assign tx_rst_o = hold_i;
    assign rx_rst_o = hold_i;
    assign tx_en_o  = ~hold_i;
    assign rx_en_o  = ~hold_i;
    assign done_o   = done_i;

endmodule

// File: rtl/rsw_ptr_reset_ctrl.sv
module rsw_ptr_reset_ctrl #(
    parameter int LANES = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             rate_sel_i,
    input  logic             clk_sw_done_i,
    output logic [LANES-1:0] tx_ptr_rst_o,
    output logic [LANES-1:0] rx_ptr_rst_o,
    output logic [LANES-1:0] tx_ptr_en_o,
    output logic [LANES-1:0] rx_ptr_en_o,
    output logic [LANES-1:0] lane_done_o,
    output logic             rate_o
);

    logic lvl;
    logic evt;
    logic hold;
    logic done;

    rsw_edge_detect u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (rate_sel_i),
        .lvl_o  (lvl),
        .evt_o  (evt)
    );

    rsw_seq_fsm u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .evt_i     (evt),
        .lvl_i     (lvl),
        .sw_done_i (clk_sw_done_i),
        .hold_o    (hold),
        .done_o    (done),
        .rate_o    (rate_o)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        rsw_lane_gate u_gate (
            .hold_i   (hold),
            .done_i   (done),
            .tx_rst_o (tx_ptr_rst_o[g]),
            .rx_rst_o (rx_ptr_rst_o[g]),
            .tx_en_o  (tx_ptr_en_o[g]),
            .rx_en_o  (rx_ptr_en_o[g]),
            .done_o   (lane_done_o[g])
        );
    end

endmodule

// File: rtl/rsw_ptr_reset_ctrl_chk.sv
module rsw_ptr_reset_ctrl_chk #(
    parameter int LANES = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             rate_sel_i,
    input logic             clk_sw_done_i,
    input logic [LANES-1:0] tx_ptr_rst_o,
    input logic [LANES-1:0] rx_ptr_rst_o,
    input logic [LANES-1:0] tx_ptr_en_o,
    input logic [LANES-1:0] rx_ptr_en_o,
    input logic [LANES-1:0] lane_done_o,
    input logic             rate_o
);

    a_r2_hold_after_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rate_sel_i, 2) != $past(rate_sel_i, 3)) |-> (&tx_ptr_rst_o && &rx_ptr_rst_o));

    a_r3_lanes_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($countones(tx_ptr_rst_o) == 0 || $countones(tx_ptr_rst_o) == LANES)
        && (tx_ptr_rst_o == rx_ptr_rst_o) && (tx_ptr_en_o == ~rx_ptr_rst_o)
        && (rx_ptr_en_o == ~tx_ptr_rst_o));

    a_r4_release_needs_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(tx_ptr_rst_o[0]) |-> $past(clk_sw_done_i));

    a_r5_done_follows_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lane_done_o[0] |-> ($past(tx_ptr_rst_o) == '0 && $past(tx_ptr_rst_o, 2) == '1));

    a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lane_done_o[0] |=> (lane_done_o == '0));

    a_r5_done_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(lane_done_o) == 0 || $countones(lane_done_o) == LANES);

    a_r6_rate_moves_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(rate_o) |-> lane_done_o[0]);

endmodule

bind rsw_ptr_reset_ctrl rsw_ptr_reset_ctrl_chk #(.LANES(LANES)) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .rate_sel_i    (rate_sel_i),
    .clk_sw_done_i (clk_sw_done_i),
    .tx_ptr_rst_o  (tx_ptr_rst_o),
    .rx_ptr_rst_o  (rx_ptr_rst_o),
    .tx_ptr_en_o   (tx_ptr_en_o),
    .rx_ptr_en_o   (rx_ptr_en_o),
    .lane_done_o   (lane_done_o),
    .rate_o        (rate_o)
);

// File: tb/rsw_ptr_reset_ctrl_bench.sv
module rsw_ptr_reset_ctrl_bench;

    localparam int LANES = 8;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             rate_sel_i = 1'b0;
    logic             clk_sw_done_i = 1'b0;
    logic [LANES-1:0] tx_ptr_rst_o, rx_ptr_rst_o, tx_ptr_en_o, rx_ptr_en_o, lane_done_o;
    logic             rate_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic exp_rate = 1'b0;

    always #2 clk_i = ~clk_i;

    rsw_ptr_reset_ctrl #(.LANES(LANES)) u_rsw_ptr_reset_ctrl (
        .clk_i, .rst_ni, .rate_sel_i, .clk_sw_done_i,
        .tx_ptr_rst_o, .rx_ptr_rst_o, .tx_ptr_en_o, .rx_ptr_en_o,
        .lane_done_o, .rate_o
    );

    task automatic tick();
        @(posedge clk_i);
        #1;
    endtask

    task automatic chk(string req, logic e_hold, logic e_done, logic e_rate);
        logic [LANES-1:0] h, d;
        h = {LANES{e_hold}};
        d = {LANES{e_done}};
        n_cmp++;
        if (tx_ptr_rst_o !== h || rx_ptr_rst_o !== h || tx_ptr_en_o !== ~h ||
            rx_ptr_en_o !== ~h || lane_done_o !== d || rate_o !== e_rate) begin
            n_bad++;
            $display("FAIL %s: rst tx/rx=%b/%b en tx/rx=%b/%b done=%b rate=%b ; expected rst=%b en=%b done=%b rate=%b",
                     req, tx_ptr_rst_o, rx_ptr_rst_o, tx_ptr_en_o, rx_ptr_en_o,
                     lane_done_o, rate_o, h, ~h, d, e_rate);
        end
    endtask

    task automatic pulse_done();
        clk_sw_done_i = 1'b1;
        tick();
        clk_sw_done_i = 1'b0;
    endtask

    // full switch to new_lvl with w extra hold cycles
    task automatic full_switch(logic new_lvl, int w);
        rate_sel_i = new_lvl;
        tick();
        chk("R2 pre-hold", 1'b0, 1'b0, exp_rate);
        tick();
        chk("R2 hold entered", 1'b1, 1'b0, exp_rate);
        for (int i = 0; i < w; i++) begin
            tick();
            chk("R4 hold kept", 1'b1, 1'b0, exp_rate);
        end
        pulse_done();
        chk("R4 released", 1'b0, 1'b0, exp_rate);
        tick();
        exp_rate = new_lvl;
        chk("R5 R6 done pulse", 1'b0, 1'b1, exp_rate);
        tick();
        chk("R5 done single", 1'b0, 1'b0, exp_rate);
    endtask

    initial begin
        #400000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        chk("R1 in reset", 1'b0, 1'b0, 1'b0);
        rst_ni = 1'b1;
        tick();
        chk("R1 after reset", 1'b0, 1'b0, 1'b0);

        // R7: stray switch-done while idle
        pulse_done();
        chk("R7 idle done ignored", 1'b0, 1'b0, 1'b0);
        repeat (2) begin
            tick();
            chk("R7 idle still quiet", 1'b0, 1'b0, 1'b0);
        end

        // both directions, several hold lengths
        for (int w = 0; w < 6; w++) begin
            full_switch(~exp_rate, w);
            full_switch(~exp_rate, w);
        end

        // R8: change during hold, coinciding with switch-done
        rate_sel_i = ~exp_rate;
        tick();
        tick();
        chk("R8 hold A", 1'b1, 1'b0, exp_rate);
        rate_sel_i = exp_rate;
        tick();
        clk_sw_done_i = 1'b1;
        tick();
        clk_sw_done_i = 1'b0;
        chk("R8 change beats done", 1'b1, 1'b0, exp_rate);
        tick();
        chk("R8 hold restarted", 1'b1, 1'b0, exp_rate);
        pulse_done();
        chk("R8 released", 1'b0, 1'b0, exp_rate);
        tick();
        chk("R8 R6 back-to-start rate", 1'b0, 1'b1, exp_rate);
        tick();
        chk("R8 idle", 1'b0, 1'b0, exp_rate);

        // R8: change sampled in the release cycle suppresses done
        rate_sel_i = ~exp_rate;
        tick();
        tick();
        chk("R8 hold B", 1'b1, 1'b0, exp_rate);
        rate_sel_i = exp_rate;
        clk_sw_done_i = 1'b1;
        tick();
        clk_sw_done_i = 1'b0;
        chk("R8 release cycle", 1'b0, 1'b0, exp_rate);
        tick();
        chk("R8 rehold no done", 1'b1, 1'b0, exp_rate);
        repeat (2) begin
            tick();
            chk("R8 rehold kept", 1'b1, 1'b0, exp_rate);
        end
        pulse_done();
        chk("R8 release B", 1'b0, 1'b0, exp_rate);
        tick();
        chk("R8 R6 done B", 1'b0, 1'b1, exp_rate);
        tick();
        chk("R3 final idle", 1'b0, 1'b0, exp_rate);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule